// File: doc/BRIEF.md
# Time-of-Day Counter with Atomic Actions

This block keeps a free-running wall-clock time. The value has a 48-bit seconds part and a 30-bit nanoseconds part. On every clock edge the time moves forward by a nominal nanosecond step, which is a parameter. A separate rate trimmer can lengthen that step by one nanosecond or shorten it by one on any cycle. When the nanoseconds reach one second they wrap, and the seconds carry across all 48 bits.

Software reaches the counter through a small register port. The port has a write strobe, a 2-bit address, 32-bit write data and combinational read data. Behind the port sit three staging registers (seconds-high, seconds-low, nanoseconds) and a command register with a 2-bit action code. A nonzero action moves the control state machine from IDLE to EXEC. The action takes effect on the next edge, and the machine then always returns from EXEC to IDLE. There are three actions:
- snapshot copies the live time into staging so it can be read coherently;
- load replaces the live time with the staged value;
- delta adds the staged nanoseconds, taken as a signed number, to the running time in one step.

A small negative nanosecond result, between -16 and -1, is kept as a 30-bit wrapped value just under 2^30. It stands for the previous second. The next increments carry it back to a normal value.

Top module: `tod_counter`

## Requirements
- R1: After reset the live time, all staging registers and the command readback are zero.
- R2: With no action and no trim, each edge adds INC_NS (default 8) to the nanoseconds. A sum of 1,000,000,000 or more subtracts 10^9 and increments the 48-bit seconds, carrying from the low 32 bits into the high 16.
- R3: The trim input `trim_up` makes that edge's step INC_NS+1, and `trim_dn` makes it INC_NS-1. With both inputs high the step is INC_NS.
- R4: Address map: 0 is the command register (action in bits 1:0), 1 is seconds-high (bits 15:0), 2 is seconds-low (bits 31:0) and 3 is nanoseconds (bits 29:0). Unused upper read bits are zero.
- R5: Action codes are 0 idle, 1 snapshot, 2 load and 3 delta. A nonzero write at address 0 executes once, on the edge after the write. During that one cycle the command register reads back the code, and afterwards it reads 0. Writing 0 does nothing.
- R6: Snapshot stores into staging the live time seen in the cycle between the command write and its execution.
- R7: Load sets the live time to the staged seconds and nanoseconds at the execute edge, with no step added on that edge.
- R8: Delta sets the live time to the old time plus INC_NS plus the staged nanoseconds, read as 30-bit two's complement, with carry or borrow into seconds. Staged seconds are ignored.
- R9: A delta whose magnitude is 500,000,000 ns or more is ignored, and the time simply advances by INC_NS.
- R10: A result from -16 to -1 ns is stored as 2^30 plus that value, and the seconds are left unchanged. A result below -16 adds 10^9 and decrements the seconds. Stored nanoseconds are always below 10^9 or at least 0x3FFFFFF0.
- R11: Writes at any address during the EXEC cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_wr | input | 1 | Register write strobe |
| acc_addr | input | 2 | Register address |
| acc_wdata | input | 32 | Register write data |
| acc_rdata | output | 32 | Register read data (combinational) |
| trim_up | input | 1 | Add one nanosecond to this cycle's step |
| trim_dn | input | 1 | Remove one nanosecond from this cycle's step |
| tod_sec | output | 48 | Live seconds |
| tod_nsec | output | 30 | Live nanoseconds |

## Verification
A stuck control state would show up one cycle after a command write. The command readback would stay nonzero, or a second action would fire or be lost. A wrong normalisation shows up on the first edge that crosses a second or goes negative, as a nanosecond value outside both legal ranges or a seconds value that is off by one. Staging corruption shows up only when software reads the staging registers back or issues a later load, so the directed scenarios read staging back right after every action that could have touched it.

// File: rtl/tod_pkg.sv
package tod_pkg;
    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_SNAP  = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_DELTA = 2'd3
    } act_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } st_e;

    localparam logic [1:0] A_CMD   = 2'd0;
    localparam logic [1:0] A_SECHI = 2'd1;
    localparam logic [1:0] A_SECLO = 2'd2;
    localparam logic [1:0] A_NSEC  = 2'd3;

    localparam int NS_PER_SEC = 1000000000;
    localparam int NEG_WIN    = 16;
endpackage

// File: rtl/tod_ctrl.sv
module tod_ctrl
    import tod_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [1:0] addr,
    input  logic [1:0] code,
    output act_e       exec_act,
    output logic       accept
);
    st_e  state, state_nx;
    act_e pend, pend_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pend  <= ACT_IDLE;
        end else begin
            state <= state_nx;
            pend  <= pend_nx;
        end
    end

    always_comb begin
        state_nx = state;
        pend_nx  = pend;
        unique case (state)
            ST_IDLE: begin
                if (wr && addr == A_CMD && code != 2'd0) begin
                    state_nx = ST_EXEC;
                    pend_nx  = act_e'(code);
                end
            end
            ST_EXEC: begin
                state_nx = ST_IDLE;
                pend_nx  = ACT_IDLE;
            end
        endcase
    end

    always_comb begin
        exec_act = (state == ST_EXEC) ? pend : ACT_IDLE;
        accept   = (state == ST_IDLE);
    end

    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_EXEC |=> state == ST_IDLE); // R5
endmodule

// File: rtl/tod_stage.sv
module tod_stage
    import tod_pkg::*;
#(
    parameter int SEC_W = 48,
    parameter int NS_W  = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [1:0]       addr,
    input  logic [31:0]      wdata,
    input  logic             accept,
    input  act_e             exec_act,
    input  logic [SEC_W-1:0] live_sec,
    input  logic [NS_W-1:0]  live_nsec,
    output logic [SEC_W-1:0] stg_sec,
    output logic [NS_W-1:0]  stg_nsec,
    output logic [31:0]      rdata
);
    localparam int HI_W = SEC_W - 32;

    logic [HI_W-1:0] stg_hi;
    logic [31:0]     stg_lo;
    logic            snap;
    logic            unused_bits;

    assign unused_bits = ^{wdata[31:HI_W], wdata[31:NS_W]};
    assign snap        = (exec_act == ACT_SNAP);
    assign stg_sec     = {stg_hi, stg_lo};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_hi   <= '0;
            stg_lo   <= '0;
            stg_nsec <= '0;
        end else if (snap) begin
            stg_hi   <= live_sec[SEC_W-1:32];
            stg_lo   <= live_sec[31:0];
            stg_nsec <= live_nsec;
        end else if (wr && accept) begin
            case (addr)
                A_SECHI: stg_hi   <= wdata[HI_W-1:0];
                A_SECLO: stg_lo   <= wdata;
                A_NSEC:  stg_nsec <= wdata[NS_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            A_CMD:   rdata = {30'd0, exec_act};
            A_SECHI: rdata = {{(32-HI_W){1'b0}}, stg_hi};
            A_SECLO: rdata = stg_lo;
            default: rdata = {{(32-NS_W){1'b0}}, stg_nsec};
        endcase
    end

    AST_STAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !snap) |=> ($stable(stg_sec) && $stable(stg_nsec))); // R11
endmodule

// File: rtl/tod_next.sv
module tod_next
    import tod_pkg::*;
#(
    parameter int SEC_W = 48,
    parameter int NS_W  = 30,
    parameter int INC_W = 8
) (
    input  logic [SEC_W-1:0] cur_sec,
    input  logic [NS_W-1:0]  cur_nsec,
    input  logic [INC_W-1:0] step,
    input  logic             delta_en,
    input  logic [NS_W-1:0]  delta,
    output logic [SEC_W-1:0] nx_sec,
    output logic [NS_W-1:0]  nx_nsec
);
    localparam int SUM_W = NS_W + 2;
    localparam logic signed [SUM_W-1:0] ONE_SEC   = SUM_W'(NS_PER_SEC);
    localparam logic signed [SUM_W-1:0] NEG_FLOOR = -SUM_W'(NEG_WIN);
    localparam logic [NS_W-1:0]         WIN_LO    = {NS_W{1'b1}} - NS_W'(NEG_WIN - 1);

    logic                    in_win;
    logic signed [SUM_W-1:0] base, dsx, sum;

    always_comb begin
        in_win = (cur_nsec >= WIN_LO);
        base   = {{2{in_win}}, cur_nsec};
        dsx    = delta_en ? {{2{delta[NS_W-1]}}, delta} : '0;
        sum    = base + signed'(SUM_W'(step)) + dsx;
        if (sum >= ONE_SEC) begin
            nx_nsec = NS_W'(sum - ONE_SEC);
            nx_sec  = cur_sec + SEC_W'(1);
        end else if (sum < NEG_FLOOR) begin
            nx_nsec = NS_W'(sum + ONE_SEC);
            nx_sec  = cur_sec - SEC_W'(1);
        end else begin
            nx_nsec = NS_W'(sum);
            nx_sec  = cur_sec;
        end
    end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
#(
    parameter int INC_NS = 8,
    parameter int SEC_W  = 48,
    parameter int NS_W   = 30,
    parameter int INC_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_wr,
    input  logic [1:0]       acc_addr,
    input  logic [31:0]      acc_wdata,
    output logic [31:0]      acc_rdata,
    input  logic             trim_up,
    input  logic             trim_dn,
    output logic [SEC_W-1:0] tod_sec,
    output logic [NS_W-1:0]  tod_nsec
);
    localparam int SUM_W = NS_W + 2;
    localparam logic signed [SUM_W-1:0] HALF = SUM_W'(NS_PER_SEC / 2);

    act_e                    exec_act;
    logic                    accept;
    logic [SEC_W-1:0]        stg_sec, nx_sec;
    logic [NS_W-1:0]         stg_nsec, nx_nsec;
    logic [INC_W-1:0]        step;
    logic signed [SUM_W-1:0] dval;
    logic                    delta_en;

    tod_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (acc_wr),
        .addr     (acc_addr),
        .code     (acc_wdata[1:0]),
        .exec_act (exec_act),
        .accept   (accept)
    );

    tod_stage #(.SEC_W(SEC_W), .NS_W(NS_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (acc_wr),
        .addr      (acc_addr),
        .wdata     (acc_wdata),
        .accept    (accept),
        .exec_act  (exec_act),
        .live_sec  (tod_sec),
        .live_nsec (tod_nsec),
        .stg_sec   (stg_sec),
        .stg_nsec  (stg_nsec),
        .rdata     (acc_rdata)
    );

    always_comb begin
        step     = INC_W'(INC_NS) + INC_W'(trim_up) - INC_W'(trim_dn);
        dval     = {{2{stg_nsec[NS_W-1]}}, stg_nsec};
        delta_en = (exec_act == ACT_DELTA) && (dval > -HALF) && (dval < HALF);
    end

    tod_next #(.SEC_W(SEC_W), .NS_W(NS_W), .INC_W(INC_W)) u_next (
        .cur_sec  (tod_sec),
        .cur_nsec (tod_nsec),
        .step     (step),
        .delta_en (delta_en),
        .delta    (stg_nsec),
        .nx_sec   (nx_sec),
        .nx_nsec  (nx_nsec)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tod_sec  <= '0;
            tod_nsec <= '0;
        end else if (exec_act == ACT_LOAD) begin
            tod_sec  <= stg_sec;
            tod_nsec <= stg_nsec;
        end else begin
            tod_sec  <= nx_sec;
            tod_nsec <= nx_nsec;
        end
    end

    AST_NSEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (tod_nsec < NS_W'(NS_PER_SEC)) || (tod_nsec >= {NS_W{1'b1}} - NS_W'(NEG_WIN - 1))); // R10

    AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_act != ACT_LOAD && exec_act != ACT_DELTA && !trim_up && !trim_dn
         && tod_nsec < NS_W'(NS_PER_SEC - INC_NS))
        |=> (tod_nsec == $past(tod_nsec) + NS_W'(INC_NS) && $stable(tod_sec))); // R2

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        exec_act == ACT_LOAD |=> (tod_sec == $past(stg_sec) && tod_nsec == $past(stg_nsec))); // R7
endmodule

// File: tb/sim_tod_counter.sv
module sim_tod_counter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_wr = 1'b0;
    logic [1:0]  acc_addr = 2'd0;
    logic [31:0] acc_wdata = 32'd0;
    logic [31:0] acc_rdata;
    logic        trim_up = 1'b0;
    logic        trim_dn = 1'b0;
    logic [47:0] tod_sec;
    logic [29:0] tod_nsec;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tod_counter u0 (
        .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .trim_up(trim_up),
        .trim_dn(trim_dn), .tod_sec(tod_sec), .tod_nsec(tod_nsec)
    );

    task automatic chk(input string tag, input logic [77:0] got, input logic [77:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [77:0] now_tod();
        return {tod_sec, tod_nsec};
    endfunction

    // expected time after adding d ns to (s, n), per R2/R8/R10
    function automatic logic [77:0] f_add(input logic [77:0] t, input longint d);
        logic [47:0] s;
        longint v;
        s = t[77:30];
        v = longint'(t[29:0]);
        if (t[29:0] >= 30'h3FFFFFF0) v = v - (64'sd1 << 30);
        v = v + d;
        if (v >= 64'sd1000000000) begin
            v = v - 64'sd1000000000;
            s = s + 48'd1;
        end else if (v < -64'sd16) begin
            v = v + 64'sd1000000000;
            s = s - 48'd1;
        end
        return {s, v[29:0]};
    endfunction

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] v);
        acc_addr = a;
        #1;
        v = acc_rdata;
    endtask

    task automatic stage(input logic [15:0] hi, input logic [31:0] lo, input logic [29:0] ns);
        wr_reg(2'd1, {16'd0, hi});
        wr_reg(2'd2, lo);
        wr_reg(2'd3, {2'd0, ns});
    endtask

    // issue an action; t_mid is the live time between write and execution
    task automatic issue(input logic [1:0] code, output logic [77:0] t_mid);
        logic [31:0] v;
        wr_reg(2'd0, {30'd0, code});
        t_mid = now_tod();
        rd_reg(2'd0, v);
        chk("R5 command readback during exec", 78'(v), 78'(code));
        @(negedge clk);
        rd_reg(2'd0, v);
        chk("R5 command back to idle", 78'(v), 78'd0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 live time zero", now_tod(), 78'd0);
        for (int a = 0; a < 4; a++) begin
            rd_reg(a[1:0], v);
            chk("R1 register zero", 78'(v), 78'd0);
        end
    endtask

    task automatic t_advance();
        logic [77:0] a;
        @(negedge clk);
        a = now_tod();
        @(negedge clk);
        chk("R2 plain step", now_tod(), f_add(a, 8));
    endtask

    task automatic t_trim();
        logic [77:0] a;
        @(negedge clk); trim_up = 1'b1; a = now_tod();
        @(negedge clk); chk("R3 trim up", now_tod(), f_add(a, 9));
        trim_up = 1'b0; trim_dn = 1'b1; a = now_tod();
        @(negedge clk); chk("R3 trim down", now_tod(), f_add(a, 7));
        trim_up = 1'b1; a = now_tod();
        @(negedge clk); chk("R3 trim both", now_tod(), f_add(a, 8));
        trim_up = 1'b0; trim_dn = 1'b0;
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr_reg(2'd1, 32'hABCD1234);
        wr_reg(2'd2, 32'hDEADBEEF);
        wr_reg(2'd3, 32'hFFFFFFFF);
        rd_reg(2'd1, v); chk("R4 seconds high", 78'(v), 78'h1234);
        rd_reg(2'd2, v); chk("R4 seconds low", 78'(v), 78'hDEADBEEF);
        rd_reg(2'd3, v); chk("R4 nanoseconds", 78'(v), 78'h3FFFFFFF);
        rd_reg(2'd0, v); chk("R4 command idle", 78'(v), 78'd0);
    endtask

    task automatic t_zero_cmd();
        logic [77:0] a;
        logic [31:0] v;
        @(negedge clk); a = now_tod();
        wr_reg(2'd0, 32'd0);
        rd_reg(2'd0, v);
        chk("R5 zero write no action", 78'(v), 78'd0);
        chk("R5 zero write time runs", now_tod(), f_add(f_add(a, 8), 8));
    endtask

    task automatic t_load_roll();
        logic [77:0] m;
        stage(16'h0000, 32'hFFFFFFFF, 30'd999999996);
        issue(2'd2, m);
        chk("R7 load value", now_tod(), {48'h0000FFFFFFFF, 30'd999999996});
        @(negedge clk);
        chk("R2 rollover with carry", now_tod(), {48'h000100000000, 30'd4});
    endtask

    task automatic t_snapshot();
        logic [77:0] m;
        logic [31:0] hi, lo, ns;
        issue(2'd1, m);
        rd_reg(2'd1, hi); rd_reg(2'd2, lo); rd_reg(2'd3, ns);
        chk("R6 snapshot", {hi[15:0], lo, ns[29:0]}, m);
        chk("R6 live unaffected", now_tod(), f_add(m, 8));
    endtask

    task automatic t_delta_pos();
        logic [77:0] m;
        stage(16'h0000, 32'd10, 30'd999999000);
        issue(2'd2, m);
        wr_reg(2'd2, 32'h55);
        wr_reg(2'd3, 32'd2000);
        issue(2'd3, m);
        chk("R8 positive delta crossing second", now_tod(), f_add(m, 2008));
    endtask

    task automatic t_delta_neg_borrow();
        logic [77:0] m;
        stage(16'h0000, 32'd20, 30'd100);
        issue(2'd2, m);
        wr_reg(2'd3, 32'hFFFFFC18);  // -1000
        issue(2'd3, m);
        chk("R8 negative delta borrow", now_tod(), f_add(m, 8 - 1000));
        chk("R10 borrow decremented seconds", 78'(now_tod() >> 30), 78'd19);
    endtask

    task automatic t_window();
        logic [77:0] m;
        stage(16'h0000, 32'd7, 30'd0);
        issue(2'd2, m);
        wr_reg(2'd3, 32'hFFFFFFD4);  // -44; live reaches 32 when sampled
        issue(2'd3, m);
        chk("R10 pre-delta time", m, {48'd7, 30'd32});
        chk("R10 wrapped small negative", now_tod(), {48'd7, 30'h3FFFFFFC});
        @(negedge clk);
        chk("R10 recovers from window", now_tod(), {48'd7, 30'd4});
        stage(16'h0000, 32'd9, 30'h3FFFFFF0);
        issue(2'd2, m);
        @(negedge clk);
        chk("R10 window advance", now_tod(), {48'd9, 30'h3FFFFFF8});
    endtask

    task automatic t_reject();
        logic [77:0] m;
        wr_reg(2'd3, 32'd500000000);
        issue(2'd3, m);
        chk("R9 +half second ignored", now_tod(), f_add(m, 8));
        wr_reg(2'd3, 32'hE2329B00);  // -500000000
        issue(2'd3, m);
        chk("R9 -half second ignored", now_tod(), f_add(m, 8));
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        stage(16'h0000, 32'd3, 30'd100);
        @(negedge clk);
        acc_wr = 1'b1; acc_addr = 2'd0; acc_wdata = 32'd2;
        @(negedge clk);
        acc_addr = 2'd3; acc_wdata = 32'd777;
        @(negedge clk);
        acc_wr = 1'b0;
        chk("R11 load not disturbed", now_tod(), {48'd3, 30'd100});
        rd_reg(2'd3, v);
        chk("R11 staging write ignored", 78'(v), 78'd100);
        rd_reg(2'd0, v);
        chk("R11 no second action", 78'(v), 78'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_advance();
        t_trim();
        t_map();
        t_zero_cmd();
        t_load_roll();
        t_snapshot();
        t_delta_pos();
        t_delta_neg_borrow();
        t_window();
        t_reject();
        t_busy_ignore();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule